// File: doc/BRIEF.md
# Dual-Slope Time Interpolator Controller

This block sequences a time-stretching interpolator that resolves fractions of a clock period. An asynchronous event switches on a large capacitor charge current at once. The charge stays on until the clock edge at which the event has passed through a two-stage synchronizer. The block then switches to a discharge current that is nominally one thousandth as large. It counts clock cycles until an external zero-crossing comparator reports that the capacitor is empty. Each counted cycle stands for about 1/1000 of a clock period of the original interval, so a 100 MHz clock gives 10 ps per count.

The comparator passes through a two-flop synchronizer of its own, and the fixed latency this adds is removed from the reported count. A result appears as a one-cycle valid pulse with the count and an overflow flag. A programmable hold period then keeps both current switches off so the capacitor clamp can settle. In calibration mode, pairs of results from a short and a long known interval are compared with a target count difference. The discharge trim code is moved one step per pair toward that target, and a lock flag reports when the loop has settled.

Top module: `tdc_interp_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, both switch enables, the valid pulse, the missed-event count and the lock flag are 0, the calibration phase is 0 and the trim code is 128.
- R2: In the idle state an event drives the charge enable high without waiting for a clock. The charge enable stays high through the first rising edge after the event. At the second rising edge it falls and the discharge enable rises. The two enables are never high together.
- R3: Suppose the comparator input rises after the K-th rising edge that follows the start of discharge and before the next one. Then the valid output is high for exactly one cycle, starting at the third rising edge after that, with count K and overflow flag 0.
- R4: If the comparator never fires, the count saturates. At the 65536th rising edge after discharge starts, a result is reported with count 65535 (all ones) and overflow flag 1.
- R5: After the valid pulse, both enables stay low for hold_cycles_i + 1 cycles. The block then returns to idle and can accept a new event.
- R6: An event whose first synchronized sample falls outside the idle state is ignored. It turns on no switch and does not alter the measurement in progress. It increments the missed-event count by one, and that count saturates at all ones.
- R7: With cal_mode_i high, non-overflow results come in pairs. The first is taken while cal_phase_o is 0 (short reference) and the second while it is 1 (long reference). The error is (second - first) - cal_target_i. An error above +1 raises the trim by one, an error below -1 lowers it by one, and otherwise the trim is unchanged. The new trim is visible in the cycle after the second valid pulse.
- R8: The trim code clamps at 0 and at 255 and never wraps.
- R9: cal_lock_o goes high after 4 consecutive pairs with an error within plus or minus 1. It is cleared by any pair outside that band.
- R10: With cal_mode_i low, results leave the trim code unchanged and cal_phase_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and synchronizer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | 1 | Asynchronous event to be timed, high for at least one clock |
| cmp_i | input | 1 | Asynchronous zero-crossing comparator, high once the capacitor is empty |
| hold_cycles_i | input | 8 | Settling cycles after each result, minus one |
| cal_mode_i | input | 1 | Selects calibration use of the results |
| cal_target_i | input | 16 | Target count difference between the long and short references |
| charge_en_o | output | 1 | Large charge current switch |
| discharge_en_o | output | 1 | Small discharge current switch |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_count_o | output | 16 | Stretched count, latency-corrected |
| res_ovf_o | output | 1 | No zero crossing within the counter range |
| missed_cnt_o | output | 16 | Saturating count of ignored events |
| trim_o | output | 8 | Discharge current trim code |
| cal_phase_o | output | 1 | 0 when the short reference is expected next, 1 when the long reference is |
| cal_lock_o | output | 1 | Trim loop settled |

## Verification
The discharge begins two rising edges after the event. The result is due three edges after the comparator rises: two synchronizer flops and the state change. The bench drives every stimulus at a falling edge, counts the falling edges in between, and samples exactly where R2 and R3 place each change. It also confirms that the valid output is still low one cycle earlier. Trim, phase and lock are sampled one cycle after the second valid pulse of each pair, while the bench model predicts the analog discharge time from the current trim code. The switch enables are walked through every hold cycle, and the overflow result is awaited exactly 65536 edges after discharge starts.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DISCH,
    ST_DONE,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/tdc_sync.sv
module tdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[0] <= 1'b0;
        else         sr_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[g] <= 1'b0;
        else         sr_q[g] <= sr_q[g-1];
      end
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tdc_seq.sv
module tdc_seq
  import tdc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int HOLD_W  = 8,
  parameter int CMP_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              event_i,
  input  logic              ev_pre_i,
  input  logic              cmp_hit_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  output logic              charge_en_o,
  output logic              discharge_en_o,
  output logic              res_valid_o,
  output logic [CNT_W-1:0]  res_count_o,
  output logic              res_ovf_o,
  output logic [CNT_W-1:0]  missed_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LAT_C   = CNT_W'(CMP_LAT);

  seq_state_e        state_q, state_d;
  logic              ev_last_q;
  logic              ev_new;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_full;
  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  res_count_q;
  logic              res_ovf_q;
  logic [CNT_W-1:0]  missed_q;
  logic [CNT_W-1:0]  corrected;

  // final stage of the event shift register; its setting edge ends the charge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_last_q <= 1'b0;
    else         ev_last_q <= ev_pre_i;
  end

  assign ev_new   = ev_pre_i & ~ev_last_q;
  assign cnt_full = (cnt_q == CNT_MAX);
  assign corrected = (cnt_q >= LAT_C) ? cnt_q - LAT_C : '0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ev_new) state_d = ST_DISCH;
      ST_DISCH: if (cmp_hit_i || cnt_full) state_d = ST_DONE;
      ST_DONE:  state_d = ST_HOLD;
      ST_HOLD:  if (hold_q == '0) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      hold_q      <= '0;
      res_count_q <= '0;
      res_ovf_q   <= 1'b0;
      missed_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_DISCH)             cnt_q <= '0;
      else if (!cmp_hit_i && !cnt_full)    cnt_q <= cnt_q + 1'b1;
      if (state_q == ST_DISCH && (cmp_hit_i || cnt_full)) begin
        res_ovf_q   <= ~cmp_hit_i;
        res_count_q <= cmp_hit_i ? corrected : CNT_MAX;
      end
      if (state_q == ST_DONE)      hold_q <= hold_cycles_i;
      else if (state_q == ST_HOLD) hold_q <= hold_q - 1'b1;
      if (ev_new && state_q != ST_IDLE && missed_q != CNT_MAX)
        missed_q <= missed_q + 1'b1;
    end
  end

  assign charge_en_o    = (state_q == ST_IDLE) && !ev_last_q && (event_i || ev_pre_i);
  assign discharge_en_o = (state_q == ST_DISCH);
  assign res_valid_o    = (state_q == ST_DONE);
  assign res_count_o    = res_count_q;
  assign res_ovf_o      = res_ovf_q;
  assign missed_o       = missed_q;

  p_switch_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(charge_en_o && discharge_en_o));
  p_disch_after_charge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(discharge_en_o) |-> $past(charge_en_o));
  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  p_ovf_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ovf_o) |-> (res_count_o == CNT_MAX));
  p_hold_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> (!charge_en_o && !discharge_en_o));
  p_missed_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (missed_q == $past(missed_q)) || (missed_q == $past(missed_q) + 1'b1));
endmodule

// File: rtl/tdc_cal.sv
module tdc_cal #(
  parameter int CNT_W      = 16,
  parameter int TRIM_W     = 8,
  parameter int TRIM_INIT  = 128,
  parameter int LOCK_PAIRS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_mode_i,
  input  logic [CNT_W-1:0]  cal_target_i,
  input  logic              res_valid_i,
  input  logic [CNT_W-1:0]  res_count_i,
  input  logic              res_ovf_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              phase_o,
  output logic              lock_o
);
  localparam int EW = CNT_W + 2;
  localparam int SW = $clog2(LOCK_PAIRS + 1);
  localparam logic [TRIM_W-1:0]   TRIM_MAX = {TRIM_W{1'b1}};
  localparam logic signed [EW-1:0] E_POS   = EW'(1);
  localparam logic signed [EW-1:0] E_NEG   = -E_POS;
  localparam logic [SW-1:0]       LOCK_N   = SW'(LOCK_PAIRS);

  logic [CNT_W-1:0]     ref_q;
  logic [TRIM_W-1:0]    trim_q;
  logic                 phase_q;
  logic [SW-1:0]        streak_q;
  logic                 use_res;
  logic signed [EW-1:0] err;

  assign use_res = res_valid_i && !res_ovf_i && cal_mode_i;
  assign err = $signed({2'b00, res_count_i}) - $signed({2'b00, ref_q})
             - $signed({2'b00, cal_target_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q    <= '0;
      trim_q   <= TRIM_W'(TRIM_INIT);
      phase_q  <= 1'b0;
      streak_q <= '0;
    end else if (!cal_mode_i) begin
      phase_q <= 1'b0;
    end else if (use_res) begin
      if (!phase_q) begin
        ref_q   <= res_count_i;
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        if (err > E_POS) begin
          if (trim_q != TRIM_MAX) trim_q <= trim_q + 1'b1;
          streak_q <= '0;
        end else if (err < E_NEG) begin
          if (trim_q != '0) trim_q <= trim_q - 1'b1;
          streak_q <= '0;
        end else if (streak_q != LOCK_N) begin
          streak_q <= streak_q + 1'b1;
        end
      end
    end
  end

  assign trim_o  = trim_q;
  assign phase_o = phase_q;
  assign lock_o  = (streak_q == LOCK_N);

  p_trim_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_q == $past(trim_q)) || (trim_q == $past(trim_q) + 1'b1) ||
    (trim_q == $past(trim_q) - 1'b1));
  p_trim_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(trim_q) == TRIM_MAX) |-> (trim_q != '0));
  p_trim_bottom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(trim_q) == '0) |-> (trim_q != TRIM_MAX));
  p_lock_on_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(res_valid_i));
  p_trim_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cal_mode_i) |-> ($stable(trim_q) && !phase_q));
endmodule

// File: rtl/tdc_interp_ctrl.sv
module tdc_interp_ctrl #(
  parameter int CNT_W       = 16,
  parameter int TRIM_W      = 8,
  parameter int HOLD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TRIM_INIT   = 128,
  parameter int LOCK_PAIRS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              event_i,
  input  logic              cmp_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  input  logic              cal_mode_i,
  input  logic [CNT_W-1:0]  cal_target_i,
  output logic              charge_en_o,
  output logic              discharge_en_o,
  output logic              res_valid_o,
  output logic [CNT_W-1:0]  res_count_o,
  output logic              res_ovf_o,
  output logic [CNT_W-1:0]  missed_cnt_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              cal_phase_o,
  output logic              cal_lock_o
);
  localparam int EV_PRE_STAGES = SYNC_STAGES - 1;
  localparam int CMP_LAT       = SYNC_STAGES;

  logic ev_pre;
  logic cmp_hit;

  // event chain minus its last stage; the sequencer owns the last stage
  tdc_sync #(.STAGES(EV_PRE_STAGES)) u_ev_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (event_i),
    .q_o   (ev_pre)
  );

  tdc_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_hit)
  );

  tdc_seq #(
    .CNT_W  (CNT_W),
    .HOLD_W (HOLD_W),
    .CMP_LAT(CMP_LAT)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .event_i       (event_i),
    .ev_pre_i      (ev_pre),
    .cmp_hit_i     (cmp_hit),
    .hold_cycles_i (hold_cycles_i),
    .charge_en_o   (charge_en_o),
    .discharge_en_o(discharge_en_o),
    .res_valid_o   (res_valid_o),
    .res_count_o   (res_count_o),
    .res_ovf_o     (res_ovf_o),
    .missed_o      (missed_cnt_o)
  );

  tdc_cal #(
    .CNT_W     (CNT_W),
    .TRIM_W    (TRIM_W),
    .TRIM_INIT (TRIM_INIT),
    .LOCK_PAIRS(LOCK_PAIRS)
  ) u_cal (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cal_mode_i  (cal_mode_i),
    .cal_target_i(cal_target_i),
    .res_valid_i (res_valid_o),
    .res_count_i (res_count_o),
    .res_ovf_i   (res_ovf_o),
    .trim_o      (trim_o),
    .phase_o     (cal_phase_o),
    .lock_o      (cal_lock_o)
  );
endmodule

// File: tb/tdc_interp_ctrl_bench.sv
module tdc_interp_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 6;
  localparam int OVF_EDGES  = 65536;
  localparam int WATCHDOG   = 190000;
  localparam int VEC_K [NVEC] = '{0, 1, 5, 37, 200, 1000};
  localparam int VEC_H [NVEC] = '{0, 1, 2, 3, 7, 4};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        event_i = 1'b0;
  logic        cmp_i = 1'b0;
  logic [7:0]  hold_cycles_i = '0;
  logic        cal_mode_i = 1'b0;
  logic [15:0] cal_target_i = '0;
  logic        charge_en_o, discharge_en_o, res_valid_o, res_ovf_o;
  logic [15:0] res_count_o, missed_cnt_o;
  logic [7:0]  trim_o;
  logic        cal_phase_o, cal_lock_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tdc_interp_ctrl u_tdc_interp_ctrl (
    .clk_i, .rst_ni, .event_i, .cmp_i, .hold_cycles_i, .cal_mode_i, .cal_target_i,
    .charge_en_o, .discharge_en_o, .res_valid_o, .res_count_o, .res_ovf_o,
    .missed_cnt_o, .trim_o, .cal_phase_o, .cal_lock_o
  );

  task automatic chk(input string msg, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  // starts at a falling edge in idle, ends at the falling edge of the valid cycle
  task automatic measure(input int k, input int hold, input int inj);
    hold_cycles_i = 8'(hold);
    @(negedge clk_i);
    event_i = 1'b1;
    #1;
    chk("R2 charge on at event", charge_en_o, 1);
    chk("R2 discharge off during charge", discharge_en_o, 0);
    @(negedge clk_i);
    chk("R2 charge held past first edge", charge_en_o, 1);
    event_i = 1'b0;
    @(negedge clk_i);
    chk("R2 charge off at second edge", charge_en_o, 0);
    chk("R2 discharge on at second edge", discharge_en_o, 1);
    for (int i = 0; i < k; i++) begin
      if (i == inj) begin
        event_i = 1'b1;
        #1;
        chk("R6 late event drives no charge", charge_en_o, 0);
      end else begin
        event_i = 1'b0;
      end
      @(negedge clk_i);
    end
    event_i = 1'b0;
    cmp_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R3 valid not early", res_valid_o, 0);
    @(negedge clk_i);
    chk("R3 valid on third edge", res_valid_o, 1);
    chk("R3 count", res_count_o, k);
    chk("R3 overflow clear", res_ovf_o, 0);
    cmp_i = 1'b0;
  endtask

  function automatic int disch_len(input int trim);
    return 16 + ((255 - trim) >> 2);
  endfunction

  task automatic cal_pair(input int target, inout int trim_m, inout int streak_m);
    int err;
    cal_target_i = 16'(target);
    chk("R7 phase before short ref", cal_phase_o, 0);
    measure(8, 1, -1);
    @(negedge clk_i);
    chk("R7 phase after short ref", cal_phase_o, 1);
    @(negedge clk_i);
    measure(8 + disch_len(trim_m), 1, -1);
    err = disch_len(trim_m) - target;
    if (err > 1) begin
      if (trim_m < 255) trim_m++;
      streak_m = 0;
    end else if (err < -1) begin
      if (trim_m > 0) trim_m--;
      streak_m = 0;
    end else if (streak_m < 4) begin
      streak_m++;
    end
    @(negedge clk_i);
    chk("R7 R8 trim after pair", trim_o, trim_m);
    chk("R9 lock after pair", cal_lock_o, (streak_m == 4) ? 1 : 0);
    chk("R7 phase back to short", cal_phase_o, 0);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int trim_m;
    int streak_m;
    repeat (3) @(negedge clk_i);
    chk("R1 charge in reset", charge_en_o, 0);
    chk("R1 discharge in reset", discharge_en_o, 0);
    chk("R1 trim in reset", trim_o, 128);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid after reset", res_valid_o, 0);
    chk("R1 missed after reset", missed_cnt_o, 0);
    chk("R1 lock after reset", cal_lock_o, 0);
    chk("R1 phase after reset", cal_phase_o, 0);
    chk("R1 trim after reset", trim_o, 128);
    chk("R1 charge after reset", charge_en_o, 0);

    // table of normal measurements
    for (int v = 0; v < NVEC; v++) begin
      measure(VEC_K[v], VEC_H[v], -1);
      repeat (VEC_H[v] + 1) @(negedge clk_i);
    end
    chk("R10 trim unchanged without cal", trim_o, 128);
    chk("R10 phase zero without cal", cal_phase_o, 0);

    // event during discharge
    measure(50, 2, 10);
    chk("R6 missed after discharge event", missed_cnt_o, 1);
    repeat (3) @(negedge clk_i);

    // hold window, with an event landing in it
    measure(20, 5, -1);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk_i);
      chk("R5 charge off in hold", charge_en_o, 0);
      chk("R5 discharge off in hold", discharge_en_o, 0);
      event_i = (i == 5);
    end
    event_i = 1'b0;
    @(negedge clk_i);
    chk("R6 hold event starts nothing", charge_en_o, 0);
    @(negedge clk_i);
    chk("R6 hold event no discharge", discharge_en_o, 0);
    chk("R6 missed after hold event", missed_cnt_o, 2);
    measure(3, 0, -1);
    chk("R5 re-armed after hold", res_count_o, 3);
    @(negedge clk_i);

    // stuck comparator
    hold_cycles_i = 8'd0;
    @(negedge clk_i);
    event_i = 1'b1;
    @(negedge clk_i);
    event_i = 1'b0;
    @(negedge clk_i);
    chk("R4 discharge started", discharge_en_o, 1);
    repeat (OVF_EDGES - 1) @(negedge clk_i);
    chk("R4 no result before limit", res_valid_o, 0);
    @(negedge clk_i);
    chk("R4 valid at limit", res_valid_o, 1);
    chk("R4 saturated count", res_count_o, 65535);
    chk("R4 overflow flag", res_ovf_o, 1);
    @(negedge clk_i);
    measure(12, 1, -1);
    chk("R4 overflow clears on normal result", res_ovf_o, 0);
    repeat (2) @(negedge clk_i);

    // calibration: converge and lock
    cal_mode_i = 1'b1;
    trim_m = 128;
    streak_m = 0;
    for (int p = 0; p < 32; p++) cal_pair(40, trim_m, streak_m);
    chk("R9 locked after convergence", cal_lock_o, 1);
    // lower clamp
    for (int p = 0; p < 160; p++) cal_pair(100, trim_m, streak_m);
    chk("R8 trim clamped low", trim_o, 0);
    chk("R9 lock lost out of band", cal_lock_o, 0);
    // upper clamp
    for (int p = 0; p < 262; p++) cal_pair(0, trim_m, streak_m);
    chk("R8 trim clamped high", trim_o, 255);

    // leaving calibration
    cal_mode_i = 1'b0;
    measure(5, 1, -1);
    repeat (2) @(negedge clk_i);
    chk("R10 trim frozen after cal off", trim_o, 255);
    chk("R10 phase zero after cal off", cal_phase_o, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule